// File: doc/BRIEF.md
# NOR Flash Command Interpreter

This block models the command side of a parallel NOR flash device. It watches a bus made of chip enable, write enable, output enable, an address, a 16-bit data path and a byte/word select, all sampled on a system clock. A write is taken when write enable rises while chip enable is low. Multi-write unlock sequences move the block out of its default array-read mode. The sequences lead to an identifier mode, a single-location program, or a sector erase. A small built-in cell array stands in for the flash storage.

A program or erase starts a busy period of a fixed number of clocks. During that period reads return a status byte instead of array data. Any write that breaks a sequence sends the block straight back to array reads. Suspend and resume are honoured only while an erase is in progress. Reads are combinational from the registered state and the present address, and the data bus is zero whenever chip enable or output enable is high.

Top module: `nor_cmd_iface`

## Requirements
- R1: After reset the block is in array-read mode: a read returns the stored word with no command written first, and every cell starts at 0xFFFF.
- R2: A write with the wrong address or the wrong data at any step of an unlock, program or erase sequence abandons that sequence and leaves the block in array-read mode.
- R3: Only wdata[7:0] is decoded as a command; wdata[15:8] has no effect on command writes.
- R4: A single 0xF0 write at any address, or 0xAA, 0x55, 0xF0 as a three-write sequence, leaves identifier mode and returns to array reads. While the 0xAA and 0x55 steps are pending, reads still return identifier data.
- R5: Identifier mode is entered with 0xAA at key 1, 0x55 at key 2 and 0x90 at key 1. In word mode, address bits 1:0 give the offset: 0 returns 0x0004 and 1 returns 0x22C4. In byte mode, address bits 2:0 give the offset: 0 returns 0x04 and 2 returns 0xC4. Other offsets return 0.
- R6: The manufacturer and device identifier bytes have odd parity across bits 7:0.
- R7: In identifier mode, word offset 2 or byte offset 4 returns bit 0 = 1 when the addressed sector is protected. Sectors are the top two bits of the 6-bit word index, and by default only sector 1 is protected.
- R8: Program takes four writes: 0xAA at key 1, 0x55 at key 2, 0xA0 at key 1, then the data at the target. Key 1/key 2 are word address 0x555/0x2AA in word mode and byte address 0xAAA/0x555 in byte mode.
- R9: For PROG_CYC clocks after the final program write, every read returns 0x00 in bits 15:8 and 6:0, with bit 7 set to the complement of written bit 7. Afterwards the block reads the array again.
- R10: Every write accepted while a program is busy is ignored.
- R11: Programming stores the bitwise AND of the old cell contents and the written data.
- R12: Erase is 0xAA, 0x55, 0x80, 0xAA, 0x55 at keys 1, 2, 1, 1, 2, then 0x30 at any address inside the target sector. Reads return 0x0000 during ERASE_CYC clocks, after which every word of that sector is 0xFFFF.
- R13: 0xB0 suspends a running erase: the count freezes and reads return array data. Then 0x30 resumes the erase. Outside an erase, 0xB0 is an invalid write and changes nothing.
- R14: In byte mode, the word index is address bits 6:1 and address bit 0 selects the lane (0 = low byte). The read returns that byte with bits 15:8 zero. A byte program affects only its own lane, and the complement of that byte's bit 7 is used for the polling status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken when it rises |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = 16-bit word bus, 0 = byte bus |
| addr | input | ADDR_W | Word address (word mode) or byte address (byte mode) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero while not selected for read |

## Verification
A sequencer left in the wrong step shows up at the ports on the very next read. That read returns identifier codes instead of array data, or the reverse, or a later write is taken where it should have been refused. A busy counter that is off by even one clock gives a read in the edge cycle the status byte when array data is due, or array data when the status byte is due. The cycle-exact reference model catches this on that same clock. A faulty program or erase commit is seen as wrong cell contents at the first read afterwards. That includes a lane mix-up, an OR in place of an AND, and a wrong sector.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_ASEL,
        ST_U1,
        ST_U2,
        ST_PSET,
        ST_ESET,
        ST_EU1,
        ST_EU2,
        ST_PBUSY,
        ST_EBUSY,
        ST_ESUSP
    } nor_st_e;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESUME  = 8'h30;

endpackage

// File: rtl/nor_bus_sampler.sv
module nor_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic wr_ev
);
    logic we_d, we_q;

    always_comb begin
        we_d = we_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_d;
    end

    // a write completes on the clock that first sees write enable high again
    assign wr_ev = !ce_n && we_n && !we_q;
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
    parameter int IDX_W  = 6,
    parameter int SECT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [15:0]       wr_and,
    input  logic              ers_en,
    input  logic [SECT_W-1:0] ers_sect,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [15:0]       rd_word
);
    localparam int WORDS = 1 << IDX_W;

    logic [15:0] mem_d [WORDS];
    logic [15:0] mem_q [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = mem_q[i];
            if (ers_en && (i[IDX_W-1 -: SECT_W] == ers_sect))
                mem_d[i] = 16'hFFFF;
            if (wr_en && (wr_idx == i[IDX_W-1:0]))
                mem_d[i] = mem_q[i] & wr_and;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n) mem_q[i] <= 16'hFFFF;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/nor_id_table.sv
module nor_id_table #(
    parameter logic [7:0]  MFR_CODE = 8'h04,
    parameter logic [15:0] DEV_CODE = 16'h22C4
) (
    input  logic        word_mode,
    input  logic [2:0]  offs,
    input  logic        prot,
    output logic [15:0] id_data
);
    always_comb begin
        id_data = 16'h0000;
        if (word_mode) begin
            case (offs[1:0])
                2'd0:    id_data = {8'h00, MFR_CODE};
                2'd1:    id_data = DEV_CODE;
                2'd2:    id_data = {15'h0000, prot};
                default: id_data = 16'h0000;
            endcase
        end else begin
            case (offs)
                3'd0:    id_data = {8'h00, MFR_CODE};
                3'd2:    id_data = {8'h00, DEV_CODE[7:0]};
                3'd4:    id_data = {15'h0000, prot};
                default: id_data = 16'h0000;
            endcase
        end
    end
endmodule

// File: rtl/nor_cmd_iface.sv
module nor_cmd_iface
    import nor_cmd_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int              IDX_W     = 6,
    parameter int              SECT_W    = 2,
    parameter int              PROG_CYC  = 8,
    parameter int              ERASE_CYC = 24,
    parameter logic [7:0]      MFR_CODE  = 8'h04,
    parameter logic [15:0]     DEV_CODE  = 16'h22C4,
    parameter logic [3:0]      PROT_MAP  = 4'b0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        nor_st_e           st;
        logic              asel;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  tgt;
        logic [15:0]       mask;
        logic              pb7;
        logic [SECT_W-1:0] sect;
    } ctl_t;

    ctl_t q, d;

    logic              wr_ev;
    logic [7:0]        cmd;
    logic              key1, key2;
    logic [IDX_W-1:0]  widx;
    logic              prog_en, ers_en;
    logic [15:0]       cell_word;
    logic [15:0]       id_word;
    logic              prot_bit;
    logic [15:0]       rd_val;

    // views for the bound checker
    nor_st_e           st_now;
    logic              asel_now;
    logic              pb7_now;
    logic [IDX_W-1:0]  tgt_now;
    assign st_now   = q.st;
    assign asel_now = q.asel;
    assign pb7_now  = q.pb7;
    assign tgt_now  = q.tgt;

    nor_bus_sampler u_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .we_n  (we_n),
        .wr_ev (wr_ev)
    );

    assign cmd  = wdata[7:0];
    assign key1 = word_mode ? (addr[10:0] == 11'h555) : (addr[11:0] == 12'hAAA);
    assign key2 = word_mode ? (addr[10:0] == 11'h2AA) : (addr[11:0] == 12'h555);
    assign widx = word_mode ? addr[IDX_W-1:0] : addr[IDX_W:1];

    always_comb begin
        d       = q;
        prog_en = 1'b0;
        ers_en  = 1'b0;
        case (q.st)
            ST_PBUSY: begin
                if (q.cnt == CNT_W'(1)) begin
                    prog_en = 1'b1;
                    d.st    = ST_READ;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_EBUSY: begin
                if (wr_ev && cmd == CMD_SUSPEND) begin
                    d.st = ST_ESUSP;
                end else if (q.cnt == CNT_W'(1)) begin
                    ers_en = 1'b1;
                    d.st   = ST_READ;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_ESUSP: begin
                if (wr_ev && cmd == CMD_RESUME) d.st = ST_EBUSY;
            end
            default: begin
                if (wr_ev) begin
                    d.st = ST_READ;
                    case (q.st)
                        ST_READ, ST_ASEL: begin
                            if (key1 && cmd == CMD_KEY_A) d.st = ST_U1;
                        end
                        ST_U1: begin
                            if (key2 && cmd == CMD_KEY_B) d.st = ST_U2;
                        end
                        ST_U2: begin
                            if (key1 && cmd == CMD_PROG)       d.st = ST_PSET;
                            else if (key1 && cmd == CMD_IDENT) d.st = ST_ASEL;
                            else if (key1 && cmd == CMD_ERASE) d.st = ST_ESET;
                        end
                        ST_PSET: begin
                            d.st  = ST_PBUSY;
                            d.cnt = CNT_W'(PROG_CYC);
                            d.tgt = widx;
                            if (word_mode) begin
                                d.mask = wdata;
                                d.pb7  = wdata[7];
                            end else begin
                                d.mask = addr[0] ? {wdata[7:0], 8'hFF} : {8'hFF, wdata[7:0]};
                                d.pb7  = wdata[7];
                            end
                        end
                        ST_ESET: begin
                            if (key1 && cmd == CMD_KEY_A) d.st = ST_EU1;
                        end
                        ST_EU1: begin
                            if (key2 && cmd == CMD_KEY_B) d.st = ST_EU2;
                        end
                        ST_EU2: begin
                            if (cmd == CMD_SECTOR) begin
                                d.st   = ST_EBUSY;
                                d.cnt  = CNT_W'(ERASE_CYC);
                                d.sect = widx[IDX_W-1 -: SECT_W];
                            end
                        end
                        default: d.st = ST_READ;
                    endcase
                end
            end
        endcase
        d.asel = (d.st == ST_ASEL) || (q.asel && (d.st == ST_U1 || d.st == ST_U2));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_READ;
            q.asel <= 1'b0;
            q.cnt  <= '0;
            q.tgt  <= '0;
            q.mask <= 16'hFFFF;
            q.pb7  <= 1'b0;
            q.sect <= '0;
        end else begin
            q <= d;
        end
    end

    nor_cell_array #(.IDX_W(IDX_W), .SECT_W(SECT_W)) u_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (prog_en),
        .wr_idx   (q.tgt),
        .wr_and   (q.mask),
        .ers_en   (ers_en),
        .ers_sect (q.sect),
        .rd_idx   (widx),
        .rd_word  (cell_word)
    );

    assign prot_bit = PROT_MAP[widx[IDX_W-1 -: SECT_W]];

    nor_id_table #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_ids (
        .word_mode (word_mode),
        .offs      (addr[2:0]),
        .prot      (prot_bit),
        .id_data   (id_word)
    );

    always_comb begin
        case (q.st)
            ST_PBUSY: rd_val = {8'h00, ~q.pb7, 7'h00};
            ST_EBUSY: rd_val = 16'h0000;
            default: begin
                if (q.asel)         rd_val = id_word;
                else if (word_mode) rd_val = cell_word;
                else                rd_val = {8'h00, addr[0] ? cell_word[15:8] : cell_word[7:0]};
            end
        endcase
        rdata = (!ce_n && !oe_n) ? rd_val : 16'h0000;
    end
endmodule

// File: rtl/nor_cmd_iface_chk.sv
module nor_cmd_iface_chk
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              word_mode,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       wdata,
    input logic [15:0]       rdata,
    input logic              wr_ev,
    input nor_st_e           st,
    input logic              asel,
    input logic              pb7,
    input logic [IDX_W-1:0]  tgt
);
    logic k2, rd_on, id_offs;
    assign k2      = word_mode ? (addr[10:0] == 11'h2AA) : (addr[11:0] == 12'h555);
    assign rd_on   = !ce_n && !oe_n;
    assign id_offs = word_mode ? (addr[1:0] == 2'd0 || addr[1:0] == 2'd1)
                               : (addr[2:0] == 3'd0 || addr[2:0] == 3'd2);

    AST_BAD_SECOND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_U1 && wr_ev && !(wdata[7:0] == 8'h55 && k2)) |=> st == ST_READ); // R2

    AST_POLL_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PBUSY && rd_on) |-> (rdata[7] == !pb7 && rdata[15:8] == 8'h00)); // R9

    AST_PROG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PBUSY) |=> ((st == ST_PBUSY && $stable(tgt)) || st == ST_READ)); // R10

    AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (asel && rd_on && id_offs && st != ST_PBUSY && st != ST_EBUSY) |-> (^rdata[7:0])); // R6

    AST_SUSPEND_ONLY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_EBUSY && st != ST_ESUSP) |=> st != ST_ESUSP); // R13

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_mode && rd_on) |-> rdata[15:8] == 8'h00); // R14
endmodule

bind nor_cmd_iface nor_cmd_iface_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .word_mode (word_mode),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .wr_ev     (wr_ev),
    .st        (st_now),
    .asel      (asel_now),
    .pb7       (pb7_now),
    .tgt       (tgt_now)
);

// File: tb/sim_nor_cmd_iface.sv
`timescale 1ns/1ps
module sim_nor_cmd_iface;
    localparam int PCYC = 8;
    localparam int ECYC = 24;

    // model step codes
    localparam int M_RD = 0, M_AS = 1, M_U1 = 2, M_U2 = 3, M_PS = 4, M_ES0 = 5,
                   M_E1 = 6, M_E2 = 7, M_PB = 8, M_EB = 9, M_SU = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, word_mode = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int    errs = 0;
    int    checks = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    nor_cmd_iface #(.PROG_CYC(PCYC), .ERASE_CYC(ECYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .word_mode(word_mode), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // ---------------- reference model ----------------
    int          mst;
    bit          masel;
    int          mleft;
    logic [15:0] mmem [64];
    int          mtgt;
    logic [15:0] mmask;
    bit          mpb7;
    int          msect;
    bit          we_prev;

    always @(posedge clk) begin
        bit wr, k1, k2;
        logic [7:0] c;
        int wi, nst;
        if (!rst_n) begin
            mst = M_RD; masel = 0; mleft = 0; we_prev = 1;
            for (int i = 0; i < 64; i++) mmem[i] = 16'hFFFF;
        end else begin
            wr = !ce_n && we_n && !we_prev;
            c  = wdata[7:0];
            k1 = word_mode ? (addr[10:0] == 11'h555) : (addr == 12'hAAA);
            k2 = word_mode ? (addr[10:0] == 11'h2AA) : (addr == 12'h555);
            wi = word_mode ? int'(addr[5:0]) : int'(addr[6:1]);
            nst = mst;
            if (mst == M_PB) begin
                if (mleft == 1) begin mmem[mtgt] = mmem[mtgt] & mmask; nst = M_RD; end
                else mleft--;
            end else if (mst == M_EB) begin
                if (wr && c == 8'hB0) nst = M_SU;
                else if (mleft == 1) begin
                    for (int i = 0; i < 64; i++) if (i / 16 == msect) mmem[i] = 16'hFFFF;
                    nst = M_RD;
                end else mleft--;
            end else if (mst == M_SU) begin
                if (wr && c == 8'h30) nst = M_EB;
            end else if (wr) begin
                nst = M_RD;
                if ((mst == M_RD || mst == M_AS) && k1 && c == 8'hAA) nst = M_U1;
                if (mst == M_U1 && k2 && c == 8'h55) nst = M_U2;
                if (mst == M_U2 && k1 && c == 8'hA0) nst = M_PS;
                if (mst == M_U2 && k1 && c == 8'h90) nst = M_AS;
                if (mst == M_U2 && k1 && c == 8'h80) nst = M_ES0;
                if (mst == M_ES0 && k1 && c == 8'hAA) nst = M_E1;
                if (mst == M_E1 && k2 && c == 8'h55) nst = M_E2;
                if (mst == M_E2 && c == 8'h30) begin nst = M_EB; mleft = ECYC; msect = wi / 16; end
                if (mst == M_PS) begin
                    nst = M_PB; mleft = PCYC; mtgt = wi; mpb7 = wdata[7];
                    if (word_mode) mmask = wdata;
                    else mmask = addr[0] ? {wdata[7:0], 8'hFF} : {8'hFF, wdata[7:0]};
                end
            end
            masel = (nst == M_AS) || (masel && (nst == M_U1 || nst == M_U2));
            mst = nst;
            we_prev = we_n;
        end
    end

    function automatic logic [15:0] model_read();
        int wi;
        logic [15:0] w;
        if (ce_n || oe_n) return 16'h0000;
        if (mst == M_PB) return {8'h00, ~mpb7, 7'h00};
        if (mst == M_EB) return 16'h0000;
        wi = word_mode ? int'(addr[5:0]) : int'(addr[6:1]);
        if (masel) begin
            if (word_mode) begin
                if (addr[1:0] == 0) return 16'h0004;
                if (addr[1:0] == 1) return 16'h22C4;
                if (addr[1:0] == 2) return {15'h0, wi / 16 == 1};
                return 16'h0000;
            end
            if (addr[2:0] == 0) return 16'h0004;
            if (addr[2:0] == 2) return 16'h00C4;
            if (addr[2:0] == 4) return {15'h0, wi / 16 == 1};
            return 16'h0000;
        end
        w = mmem[wi];
        if (word_mode) return w;
        return {8'h00, addr[0] ? w[15:8] : w[7:0]};
    endfunction

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) chk(rdata, model_read(), phase);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = 0; oe_n = 1; addr = a; wdata = d; we_n = 0;
        @(negedge clk);
        we_n = 1;
        @(negedge clk);
        ce_n = 1;
    endtask

    task automatic rd(input logic [11:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        #1;
        chk(rdata, exp, tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        ce_n = 1; oe_n = 1;
        repeat (n) @(negedge clk);
    endtask

    task automatic prog_w(input logic [11:0] a, input logic [15:0] d);
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0); wr(a, d);
    endtask

    initial begin
        #20000000;
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        phase = "R1";
        rd(12'h005, 16'hFFFF, "R1");
        idle(1);
        chk(rdata, 16'h0000, "R1 deselected");

        phase = "R8";
        prog_w(12'h005, 16'h1234);
        rd(12'h005, 16'h0080, "R9 polling");
        idle(PCYC + 2);
        rd(12'h005, 16'h1234, "R8 programmed");

        phase = "R10";
        prog_w(12'h006, 16'h00F0);
        rd(12'h006, 16'h0000, "R9 polling bit7");
        wr(12'h555, 16'h00AA);
        idle(PCYC + 2);
        wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0090);
        rd(12'h000, 16'hFFFF, "R10 write during busy ignored");
        rd(12'h006, 16'h00F0, "R10 data");

        phase = "R11";
        prog_w(12'h006, 16'hFF3C);
        idle(PCYC + 2);
        rd(12'h006, 16'h0030, "R11 and");

        phase = "R2";
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h123, 16'h00A0);
        wr(12'h007, 16'h0000);
        idle(PCYC + 2);
        rd(12'h007, 16'hFFFF, "R2 bad address");
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0054); wr(12'h555, 16'h00A0);
        wr(12'h008, 16'h0000);
        idle(PCYC + 2);
        rd(12'h008, 16'hFFFF, "R2 bad data");

        phase = "R3";
        wr(12'h555, 16'h12AA); wr(12'h2AA, 16'hFF55); wr(12'h555, 16'h77A0);
        wr(12'h009, 16'h5A5A);
        idle(PCYC + 2);
        rd(12'h009, 16'h5A5A, "R3 upper byte ignored");

        phase = "R5";
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0090);
        rd(12'h000, 16'h0004, "R5 manufacturer");
        chk({15'h0, ^rdata[7:0]}, 16'h0001, "R6 parity mfr");
        rd(12'h001, 16'h22C4, "R5 device");
        chk({15'h0, ^rdata[7:0]}, 16'h0001, "R6 parity dev");
        rd(12'h012, 16'h0001, "R7 protected sector");
        rd(12'h032, 16'h0000, "R7 open sector");

        phase = "R4";
        wr(12'h000, 16'h00F0);
        rd(12'h005, 16'h1234, "R4 single reset");
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0090);
        wr(12'h555, 16'h00AA);
        rd(12'h000, 16'h0004, "R4 id kept while pending");
        wr(12'h2AA, 16'h0055); wr(12'h000, 16'h00F0);
        rd(12'h005, 16'h1234, "R4 three-write reset");

        phase = "R14";
        idle(1);
        word_mode = 0;
        wr(12'hAAA, 16'h00AA); wr(12'h555, 16'h0055); wr(12'hAAA, 16'h0090);
        rd(12'h000, 16'h0004, "R5 byte manufacturer");
        rd(12'h002, 16'h00C4, "R5 byte device");
        rd(12'h024, 16'h0001, "R7 byte protect");
        rd(12'h001, 16'h0000, "R5 byte other offset");
        wr(12'h000, 16'h00F0);
        wr(12'hAAA, 16'h00AA); wr(12'h555, 16'h0055); wr(12'hAAA, 16'h00A0);
        wr(12'h00B, 16'hFF00);
        rd(12'h00B, 16'h0080, "R9 byte polling");
        idle(PCYC + 2);
        rd(12'h00B, 16'h0000, "R14 high lane");
        rd(12'h00A, 16'h0034, "R14 low lane kept");
        idle(1);
        word_mode = 1;
        rd(12'h005, 16'h0034, "R14 word view");

        phase = "R13";
        prog_w(12'h021, 16'h00FF);
        idle(PCYC + 2);
        wr(12'h000, 16'h00B0);
        rd(12'h021, 16'h00FF, "R13 suspend outside erase");

        phase = "R12";
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0080);
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h020, 16'h0030);
        rd(12'h021, 16'h0000, "R12 erase status");
        wr(12'h000, 16'h00B0);
        rd(12'h021, 16'h00FF, "R13 suspended reads array");
        idle(2 * ECYC);
        rd(12'h021, 16'h00FF, "R13 count frozen");
        wr(12'h000, 16'h0030);
        rd(12'h021, 16'h0000, "R13 resumed");
        idle(ECYC + 4);
        rd(12'h021, 16'hFFFF, "R12 sector erased");
        rd(12'h005, 16'h0034, "R12 other sector kept");

        idle(2);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule